// File: doc/BRIEF.md
# Performance Event Counter Unit

This block keeps four 32-bit event counters for a processor core. On every clock it gets three small event counts from the pipeline: how many processor cycles went by, how many loads and stores completed, and how many floating-point instructions completed. Each counter has its own 4-bit event-select code. The code decides which of these counts, if any, is added to that counter on this edge. All four counters update on the same edge.

Two control registers hold the select codes and two interrupt enables. Counters 1 and 2 take their codes from the first control register. Counters 3 and 4 take theirs from the second. A performance-monitor interrupt request is raised when an enabled counter has its top bit set. Counter 1 has an enable of its own. Counters 2 to 4 share one enable. The request is kept by a two-state machine and stays up until the trap handler pulses a clear input.

Software reaches the counters and control registers through a plain write port and a combinational read port that share one small address map.

The interrupt machine has two states:
- `IRQ_IDLE`: no request is pending.
- `IRQ_PENDING`: a request is pending.

It has two transitions:
- `IDLE->PENDING` ("raise"): taken when the enable condition holds.
- `PENDING->IDLE` ("acknowledge"): taken when the clear input is high.

Top module: `pmu_event_unit`

## Requirements
- R1: After reset, every counter and both control registers read as zero, and `pm_irq` is low.
- R2: Select code 0 leaves a counter unchanged. So does any code that is not defined for that counter: every code other than 1 on counters 1 and 4, and every code other than 1 and 11 on counters 2 and 3.
- R3: Select code 1 adds `ev_cycles`, zero-extended, to the counter. This holds for every counter.
- R4: Select code 11 adds `ev_ldst` on counter 2 and adds `ev_fp` on counter 3.
- R5: Additions wrap modulo 2^32.
- R6: If a register write targets a counter on the same edge as an increment, the counter takes the written value and the increment is dropped.
- R7: The address map is as follows:
  - Addresses 0 to 3 are counters 1 to 4.
  - Address 4 is control A. Its fields are bits [3:0] = counter 1 select, [7:4] = counter 2 select, bit 8 = counter 1 interrupt enable, and bit 9 = shared enable for counters 2 to 4.
  - Address 5 is control B. Its fields are bits [3:0] = counter 3 select and [7:4] = counter 4 select.
  - Unused control bits read as zero. Addresses 6 and 7 read as zero.
- R8: `pm_irq` rises on the edge after the counters show one of these conditions:
  - counter 1 has bit 31 set and the counter 1 enable is on; or
  - any of counters 2 to 4 has bit 31 set and the shared enable is on.
  
  With no enabled counter at bit 31, `pm_irq` does not rise.
- R9: Once `pm_irq` is high, it stays high until a cycle with `irq_clr` high. That edge drops it. It rises again on the next edge if the condition still holds.
- R10: A control-register write changes the selects used from the following edge onward. On the write edge itself, the old selects still apply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_cycles | input | 8 | Processor cycles elapsed this clock |
| ev_ldst | input | 8 | Loads and stores completed this clock |
| ev_fp | input | 8 | Floating-point instructions completed this clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| irq_clr | input | 1 | Acknowledge for the pending interrupt |
| pm_irq | output | 1 | Sticky performance-monitor interrupt request |

## Verification
A wrong decode of a select field puts a wrong sum into a counter on the very next edge. A reference model reading back the same address sees it at once. A counter that is stuck, or that drops a carry, shows the same way one edge later. Every counter address is read in rotation, so no counter goes more than a few cycles without being compared. A wrong interrupt state appears on `pm_irq` no later than the edge after the condition changes. The bench checks that pin on every clock, including clears issued while the condition still holds.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    localparam int NUM_CNT   = 4;
    localparam int SEL_W     = 4;
    localparam int CTRL_A_W  = 2 * SEL_W + 2;
    localparam int CTRL_B_W  = 2 * SEL_W;
    localparam int EN_FIRST_BIT  = 2 * SEL_W;
    localparam int EN_SHARED_BIT = 2 * SEL_W + 1;

    localparam logic [SEL_W-1:0] SEL_HOLD   = 4'd0;
    localparam logic [SEL_W-1:0] SEL_CYCLES = 4'd1;
    localparam logic [SEL_W-1:0] SEL_ALT    = 4'd11;

    localparam int ADDR_CTRL_A = 4;
    localparam int ADDR_CTRL_B = 5;

    typedef enum logic [1:0] {
        ALT_NONE,
        ALT_LDST,
        ALT_FP
    } alt_src_e;

    typedef enum logic [1:0] {
        MODE_HOLD,
        MODE_CYCLES,
        MODE_ALT
    } lane_mode_e;

    typedef enum logic {
        IRQ_IDLE,
        IRQ_PENDING
    } irq_state_e;

    // Which extra event source a lane owns for its alternate code
    function automatic alt_src_e lane_alt(input int idx);
        if (idx == 1) return ALT_LDST;
        if (idx == 2) return ALT_FP;
        return ALT_NONE;
    endfunction

endpackage

// File: rtl/pmu_cnt_lane.sv
module pmu_cnt_lane
    import pmu_pkg::*;
#(
    parameter int       CNT_W = 32,
    parameter int       EV_W  = 8,
    parameter alt_src_e ALT   = ALT_NONE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic [EV_W-1:0]  ev_cycles,
    input  logic [EV_W-1:0]  ev_ldst,
    input  logic [EV_W-1:0]  ev_fp,
    input  logic             wr_hit,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt_q
);

    localparam int PAD_W = CNT_W - EV_W;
    localparam bit HAS_ALT = (ALT != ALT_NONE);

    lane_mode_e      mode;
    logic [EV_W-1:0] alt_ev;
    logic [EV_W-1:0] inc;

    assign alt_ev = (ALT == ALT_LDST) ? ev_ldst :
                    (ALT == ALT_FP)   ? ev_fp   : '0;

    // Decode the select code; undefined codes fall back to hold
    always_comb begin
        mode = MODE_HOLD;
        if (sel == SEL_CYCLES) begin
            mode = MODE_CYCLES;
        end else if (HAS_ALT && (sel == SEL_ALT)) begin
            mode = MODE_ALT;
        end
    end

    always_comb begin
        unique case (mode)
            MODE_HOLD:   inc = '0;
            MODE_CYCLES: inc = ev_cycles;
            MODE_ALT:    inc = alt_ev;
            default:     inc = '0;
        endcase
    end

    // Register write wins over the increment
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_hit) begin
            cnt_q <= wr_data;
        end else begin
            cnt_q <= cnt_q + {{PAD_W{1'b0}}, inc};
        end
    end

endmodule

// File: rtl/pmu_ctrl_regs.sv
module pmu_ctrl_regs
    import pmu_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [CNT_W-1:0]              wr_data,
    input  logic [ADDR_W-1:0]             rd_addr,
    input  logic [NUM_CNT-1:0][CNT_W-1:0] cnt,
    output logic [CNT_W-1:0]              rd_data,
    output logic [NUM_CNT-1:0][SEL_W-1:0] lane_sel,
    output logic                          en_first,
    output logic                          en_shared
);

    localparam int IDX_W = $clog2(NUM_CNT);

    logic [CTRL_A_W-1:0] ctrl_a_q;
    logic [CTRL_B_W-1:0] ctrl_b_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_a_q <= '0;
            ctrl_b_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(ADDR_CTRL_A)) ctrl_a_q <= wr_data[CTRL_A_W-1:0];
            if (wr_addr == ADDR_W'(ADDR_CTRL_B)) ctrl_b_q <= wr_data[CTRL_B_W-1:0];
        end
    end

    assign lane_sel[0] = ctrl_a_q[SEL_W-1:0];
    assign lane_sel[1] = ctrl_a_q[2*SEL_W-1:SEL_W];
    assign lane_sel[2] = ctrl_b_q[SEL_W-1:0];
    assign lane_sel[3] = ctrl_b_q[2*SEL_W-1:SEL_W];
    assign en_first    = ctrl_a_q[EN_FIRST_BIT];
    assign en_shared   = ctrl_a_q[EN_SHARED_BIT];

    always_comb begin
        rd_data = '0;
        if (rd_addr < ADDR_W'(NUM_CNT)) begin
            rd_data = cnt[rd_addr[IDX_W-1:0]];
        end else if (rd_addr == ADDR_W'(ADDR_CTRL_A)) begin
            rd_data = {{(CNT_W-CTRL_A_W){1'b0}}, ctrl_a_q};
        end else if (rd_addr == ADDR_W'(ADDR_CTRL_B)) begin
            rd_data = {{(CNT_W-CTRL_B_W){1'b0}}, ctrl_b_q};
        end
    end

endmodule

// File: rtl/pmu_irq_fsm.sv
module pmu_irq_fsm
    import pmu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CNT-1:0] cnt_msb,
    input  logic               en_first,
    input  logic               en_shared,
    input  logic               irq_clr,
    output logic               irq_cond,
    output logic               irq
);

    irq_state_e state_q;
    irq_state_e state_d;

    assign irq_cond = (cnt_msb[0] & en_first) |
                      ((|cnt_msb[NUM_CNT-1:1]) & en_shared);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:    if (irq_cond) state_d = IRQ_PENDING;
            IRQ_PENDING: if (irq_clr)  state_d = IRQ_IDLE;
            default:     state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq = (state_q == IRQ_PENDING);
    end

endmodule

// File: rtl/pmu_event_unit.sv
module pmu_event_unit
    import pmu_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int EV_W   = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EV_W-1:0]   ev_cycles,
    input  logic [EV_W-1:0]   ev_ldst,
    input  logic [EV_W-1:0]   ev_fp,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    input  logic              irq_clr,
    output logic              pm_irq
);

    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;
    logic [NUM_CNT-1:0][SEL_W-1:0] lane_sel;
    logic [NUM_CNT-1:0]            cnt_msb;
    logic                          en_first;
    logic                          en_shared;
    logic                          irq_cond;

    pmu_ctrl_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .cnt      (cnt_q),
        .rd_data  (rd_data),
        .lane_sel (lane_sel),
        .en_first (en_first),
        .en_shared(en_shared)
    );

    for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_lane
        pmu_cnt_lane #(
            .CNT_W(CNT_W),
            .EV_W (EV_W),
            .ALT  (lane_alt(gi))
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel      (lane_sel[gi]),
            .ev_cycles(ev_cycles),
            .ev_ldst  (ev_ldst),
            .ev_fp    (ev_fp),
            .wr_hit   (wr_en && (wr_addr == ADDR_W'(gi))),
            .wr_data  (wr_data),
            .cnt_q    (cnt_q[gi])
        );
        assign cnt_msb[gi] = cnt_q[gi][CNT_W-1];
    end

    pmu_irq_fsm u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_msb  (cnt_msb),
        .en_first (en_first),
        .en_shared(en_shared),
        .irq_clr  (irq_clr),
        .irq_cond (irq_cond),
        .irq      (pm_irq)
    );

endmodule

// File: rtl/pmu_event_unit_chk.sv
module pmu_event_unit_chk
    import pmu_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int EV_W   = 8,
    parameter int ADDR_W = 3
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_en,
    input logic [ADDR_W-1:0]             wr_addr,
    input logic [CNT_W-1:0]              wr_data,
    input logic [EV_W-1:0]               ev_cycles,
    input logic                          irq_clr,
    input logic                          pm_irq,
    input logic                          irq_cond,
    input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q,
    input logic [NUM_CNT-1:0][SEL_W-1:0] lane_sel
);

    // R6
    wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(1)) |=> (cnt_q[1] == $past(wr_data)));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_sel[0] == SEL_HOLD && !(wr_en && wr_addr == ADDR_W'(0)))
        |=> $stable(cnt_q[0]));

    // R3
    cycles_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_sel[3] == SEL_CYCLES && !(wr_en && wr_addr == ADDR_W'(3)))
        |=> (cnt_q[3] == $past(cnt_q[3]) + CNT_W'($past(ev_cycles))));

    // R8
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pm_irq) |-> $past(irq_cond));

    // R9
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_irq && !irq_clr) |=> pm_irq);

    // R9
    irq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_irq && irq_clr) |=> !pm_irq);

endmodule

bind pmu_event_unit pmu_event_unit_chk #(
    .CNT_W (CNT_W),
    .EV_W  (EV_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .ev_cycles(ev_cycles),
    .irq_clr  (irq_clr),
    .pm_irq   (pm_irq),
    .irq_cond (irq_cond),
    .cnt_q    (cnt_q),
    .lane_sel (lane_sel)
);

// File: tb/pmu_event_unit_tb.sv
`timescale 1ns/1ps
module pmu_event_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  b_cyc = '0, b_ldst = '0, b_fp = '0;
    logic        b_we = 1'b0;
    logic [2:0]  b_waddr = '0;
    logic [31:0] b_wdata = '0;
    logic [2:0]  b_raddr = '0;
    logic        b_clr = 1'b0;
    logic [31:0] rd_data;
    logic        pm_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [31:0] m_cnt [4];
    logic [31:0] m_a, m_b;
    logic        m_irq;

    always #4 clk = ~clk;

    pmu_event_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .ev_cycles(b_cyc), .ev_ldst(b_ldst), .ev_fp(b_fp),
        .wr_en(b_we), .wr_addr(b_waddr), .wr_data(b_wdata),
        .rd_addr(b_raddr), .rd_data(rd_data),
        .irq_clr(b_clr), .pm_irq(pm_irq)
    );

    function automatic logic [3:0] sel_of(int i);
        case (i)
            0: return m_a[3:0];
            1: return m_a[7:4];
            2: return m_b[3:0];
            default: return m_b[7:4];
        endcase
    endfunction

    function automatic logic [31:0] inc_of(int i);
        logic [3:0] s = sel_of(i);
        if (s == 4'd1) return {24'd0, b_cyc};
        if (s == 4'd11 && i == 1) return {24'd0, b_ldst};
        if (s == 4'd11 && i == 2) return {24'd0, b_fp};
        return 32'd0;
    endfunction

    function automatic logic [31:0] exp_rd(logic [2:0] a);
        if (a < 3'd4) return m_cnt[a[1:0]];
        if (a == 3'd4) return m_a;
        if (a == 3'd5) return m_b;
        return 32'd0;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock: advance the model from pre-edge state, then compare
    task automatic step(string tag);
        logic [31:0] n_cnt [4];
        logic [31:0] n_a = m_a, n_b = m_b;
        logic        cond, n_irq;
        for (int i = 0; i < 4; i++) begin
            n_cnt[i] = (b_we && b_waddr == 3'(i)) ? b_wdata : m_cnt[i] + inc_of(i);
        end
        if (b_we && b_waddr == 3'd4) n_a = b_wdata & 32'h3FF;
        if (b_we && b_waddr == 3'd5) n_b = b_wdata & 32'hFF;
        cond = (m_cnt[0][31] && m_a[8]) ||
               ((m_cnt[1][31] || m_cnt[2][31] || m_cnt[3][31]) && m_a[9]);
        n_irq = m_irq ? !b_clr : cond;
        @(posedge clk);
        #2;
        for (int i = 0; i < 4; i++) m_cnt[i] = n_cnt[i];
        m_a = n_a; m_b = n_b; m_irq = n_irq;
        check(tag, rd_data, exp_rd(b_raddr));
        check({tag, " irq"}, {31'd0, pm_irq}, {31'd0, m_irq});
    endtask

    task automatic cyc(logic we, logic [2:0] wa, logic [31:0] wd,
                       logic [7:0] c, logic [7:0] l, logic [7:0] f,
                       logic clr, logic [2:0] ra, string tag);
        b_we = we; b_waddr = wa; b_wdata = wd;
        b_cyc = c; b_ldst = l; b_fp = f; b_clr = clr; b_raddr = ra;
        step(tag);
        b_we = 1'b0; b_clr = 1'b0;
    endtask

    initial begin
        #(8ns * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) m_cnt[i] = '0;
        m_a = '0; m_b = '0; m_irq = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state on every address
        for (int a = 0; a < 8; a++) begin
            b_raddr = 3'(a); #1;
            check("R1", rd_data, 32'd0);
        end
        check("R1 irq", {31'd0, pm_irq}, 32'd0);
        rst_n = 1'b1;

        // R7 control readback masks unused bits; R2 code 15 holds everywhere
        cyc(1, 3'd4, 32'hFFFF_FFFF, 0, 0, 0, 0, 3'd4, "R7");
        cyc(1, 3'd5, 32'hFFFF_FFFF, 0, 0, 0, 0, 3'd5, "R7");
        cyc(0, 0, 0, 0, 0, 0, 0, 3'd6, "R7");
        for (int k = 0; k < 8; k++) cyc(0, 0, 0, 8'd9, 8'd7, 8'd5, 0, 3'(k % 4), "R2");
        cyc(1, 3'd4, 32'h0, 8'd9, 0, 0, 0, 3'd4, "R7");

        // R3 all counters on cycles; R10 selects apply from the next edge
        cyc(1, 3'd4, 32'h11, 8'd3, 0, 0, 0, 3'd0, "R10");
        cyc(1, 3'd5, 32'h11, 8'd4, 0, 0, 0, 3'd2, "R10");
        for (int k = 0; k < 12; k++) cyc(0, 0, 0, 8'(5 + k), 8'd1, 8'd2, 0, 3'(k % 4), "R3");

        // R4 alternate events; counter 4 with code 11 holds (R2); counter 1 code 0 holds
        cyc(1, 3'd4, 32'hB0, 8'd6, 0, 0, 0, 3'd1, "R4");
        cyc(1, 3'd5, 32'hBB, 8'd6, 8'd3, 8'd2, 0, 3'd2, "R4");
        for (int k = 0; k < 12; k++) cyc(0, 0, 0, 8'd100, 8'(k + 1), 8'(2 * k + 1), 0, 3'(k % 4), "R4");
        cyc(0, 0, 0, 8'd50, 8'd1, 8'd1, 0, 3'd0, "R2");
        cyc(0, 0, 0, 8'd50, 8'd1, 8'd1, 0, 3'd3, "R2");

        // R6 write beats an active increment
        cyc(1, 3'd1, 32'h1234_5678, 8'd9, 8'd9, 8'd9, 0, 3'd1, "R6");
        cyc(1, 3'd2, 32'hCAFE_0000, 8'd9, 8'd9, 8'd9, 0, 3'd2, "R6");
        cyc(0, 0, 0, 8'd1, 8'd2, 8'd3, 0, 3'd2, "R6");

        // R5 wrap on counter 1
        cyc(1, 3'd4, 32'h01, 0, 0, 0, 0, 3'd4, "R5");
        cyc(1, 3'd0, 32'hFFFF_FFF0, 8'd0, 0, 0, 0, 3'd0, "R5");
        cyc(0, 0, 0, 8'h20, 0, 0, 0, 3'd0, "R5");
        cyc(0, 0, 0, 8'h01, 0, 0, 0, 3'd0, "R5");

        // R8 counter 1 crosses bit 31 with its enable on
        cyc(1, 3'd4, 32'h101, 0, 0, 0, 0, 3'd0, "R8");
        cyc(1, 3'd0, 32'h7FFF_FFFE, 0, 0, 0, 0, 3'd0, "R8");
        cyc(0, 0, 0, 8'd1, 0, 0, 0, 3'd0, "R8");
        cyc(0, 0, 0, 8'd1, 0, 0, 0, 3'd0, "R8");
        cyc(0, 0, 0, 8'd0, 0, 0, 0, 3'd0, "R8");
        // R9 sticky, then clear while condition holds re-raises
        for (int k = 0; k < 3; k++) cyc(0, 0, 0, 0, 0, 0, 0, 3'd0, "R9");
        cyc(0, 0, 0, 0, 0, 0, 1, 3'd0, "R9");
        cyc(0, 0, 0, 0, 0, 0, 0, 3'd0, "R9");
        cyc(0, 0, 0, 0, 0, 0, 0, 3'd0, "R9");
        // remove cause, then clear: stays low
        cyc(1, 3'd4, 32'h0, 0, 0, 0, 0, 3'd4, "R9");
        cyc(0, 0, 0, 0, 0, 0, 1, 3'd0, "R9");
        for (int k = 0; k < 3; k++) cyc(0, 0, 0, 0, 0, 0, 0, 3'd0, "R9");

        // R8 shared enable on counter 4
        cyc(1, 3'd5, 32'h0, 0, 0, 0, 0, 3'd5, "R8");
        cyc(1, 3'd3, 32'h8000_0000, 0, 0, 0, 0, 3'd3, "R8");
        cyc(0, 0, 0, 0, 0, 0, 0, 3'd3, "R8");
        cyc(0, 0, 0, 0, 0, 0, 0, 3'd3, "R8");
        cyc(1, 3'd4, 32'h200, 0, 0, 0, 0, 3'd4, "R8");
        cyc(0, 0, 0, 0, 0, 0, 0, 3'd3, "R8");
        cyc(1, 3'd3, 32'h0, 0, 0, 0, 0, 3'd3, "R9");
        cyc(0, 0, 0, 0, 0, 0, 1, 3'd3, "R9");
        cyc(0, 0, 0, 0, 0, 0, 0, 3'd3, "R9");

        // Mixed traffic against the model
        for (int k = 0; k < 400; k++) begin
            logic we = ($urandom % 8) == 0;
            logic [2:0] wa = 3'($urandom % 6);
            logic [31:0] wd = (wa >= 3'd4) ? $urandom : ($urandom | ((k % 3 == 0) ? 32'h7FFF_FF00 : 32'h0));
            cyc(we, wa, wd, 8'($urandom), 8'($urandom), 8'($urandom),
                ($urandom % 6) == 0, 3'($urandom % 8), "R10");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule